// File: doc/BRIEF.md
# Eight-Pin GPIO Port Register Block

This block holds the software-visible state of one general-purpose I/O port of eight pins. A bus master reaches it through a word-addressed interface: one read strobe, one write strobe, a word address and 32-bit write data. It answers with registered read data and an error flag. The block drives the pad output value, the pad output enable and every pad configuration signal. It samples the pin levels through a synchroniser.

The output data register sits in a window of 256 words. The low eight bits of the word address act as a per-pin mask for both writes and reads, so a single store can change any chosen subset of pins without a read-modify-write. The pad configuration registers are coupled in hardware:
- Drive strength: the three selects (low, medium, high) exclude each other, so exactly one is active on every pin.
- Pulls: the pull-up and pull-down enables exclude each other.
- Open-drain: this enable stands alone.

A key-protected lock governs a commit register. For protected pins, the commit bit must be set before the alternate-function and digital-enable bits of that pin can change. Once the module clock enable rises, every access during the next three cycles is refused with an error.

Word addresses (byte offset = 4 × word address):

| Word address | Register |
|---|---|
| 0x000–0x0FF | data window |
| 0x100 | direction |
| 0x108 | alternate function |
| 0x140 | low drive |
| 0x141 | medium drive |
| 0x142 | high drive |
| 0x143 | open-drain |
| 0x144 | pull-up |
| 0x145 | pull-down |
| 0x147 | digital enable |
| 0x148 | lock |
| 0x149 | commit |

Top module: `gpio_port_regs`

## Requirements
- R1: Reset state. After reset:
  - pad_oe, pad_out, pad_pu, pad_pd, pad_od, pad_afsel and pad_den are all 0.
  - pad_drv_lo is 0xFF, and pad_drv_mid and pad_drv_hi are 0.
  - The lock register reads 1.
- R2: A write at word address A with A[9:8]=0 loads write-data bit i into data bit i only where A[i]=1. Other data bits keep their value. For example, 0xA5 at 0x0FF gives 0xA5, and a following 0xFF at 0x008 sets only bit 3.
- R3: A read at word address A with A[9:8]=0 returns the synchronised pin level in bit i where A[i]=1, and 0 in every other bit.
- R4: A write to any drive register sets the drive bits that are 1 in the data and clears the same bits in the other two drive registers. Bits written 0 are unchanged, so exactly one drive bit is set per pin.
- R5: A write to pull-up loads pull-up and clears the pull-down bits it sets. A write to pull-down works the same way in the other direction. Clearing both pulls takes two writes of zero.
- R6: The open-drain register loads its write data directly. It neither changes nor is changed by the drive or pull registers.
- R7: A write of 0xC0DE7A11 to the lock register unlocks the port. Any other value written to the lock register locks it. The lock register reads 1 while locked and 0 while unlocked.
- R8: Writes to the commit register are ignored while the port is locked. For protected pins (parameter, default 0x0F), alternate-function and digital-enable bits change only where the commit bit is 1. Unprotected pins always read back 1 in the commit register.
- R9: Any access while clk_en is low, or in the first three clock edges after clk_en rises, sets bus_err in the response cycle. Such an access has no effect, and its read data is 0.
- R10: pad_out follows the data register and pad_oe follows the direction register.
- R11: Read data is presented in the cycle after the read strobe. In any cycle with no accepted read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Module clock enable; starts the settling window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered access error |
| pin_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_drv_lo | output | 8 | Low drive strength select |
| pad_drv_mid | output | 8 | Medium drive strength select |
| pad_drv_hi | output | 8 | High drive strength select |
| pad_pu | output | 8 | Pull-up enable |
| pad_pd | output | 8 | Pull-down enable |
| pad_od | output | 8 | Open-drain enable |
| pad_afsel | output | 8 | Alternate function select |
| pad_den | output | 8 | Digital enable |

## Verification
Every register captures at the clock edge that samples the strobe, so pad outputs and read data appear one edge after the access. The bench drives strobes just after a falling edge and samples at the next falling edge, half a cycle after the capturing edge. The pin synchroniser adds two edges, so the bench settles pin_in well ahead of any data-window read. The settling window is counted edge by edge from the rise of clk_en: the bench expects errors on the first three accesses and a clean response on the fourth. Idle read data is checked one cycle after a response.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Word addresses of the configuration registers (window is below 0x100)
   localparam logic [9:0] A_DIR    = 10'h100;
   localparam logic [9:0] A_AFSEL  = 10'h108;
   localparam logic [9:0] A_DRV_LO = 10'h140;
   localparam logic [9:0] A_DRV_MD = 10'h141;
   localparam logic [9:0] A_DRV_HI = 10'h142;
   localparam logic [9:0] A_OD     = 10'h143;
   localparam logic [9:0] A_PU     = 10'h144;
   localparam logic [9:0] A_PD     = 10'h145;
   localparam logic [9:0] A_DEN    = 10'h147;
   localparam logic [9:0] A_LOCK   = 10'h148;
   localparam logic [9:0] A_COMMIT = 10'h149;

   localparam logic [31:0] UNLOCK_KEY = 32'hC0DE_7A11;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_DATA, SEL_DIR, SEL_AFSEL, SEL_DRV_LO, SEL_DRV_MD,
      SEL_DRV_HI, SEL_OD, SEL_PU, SEL_PD, SEL_DEN, SEL_LOCK, SEL_COMMIT
   } reg_sel_e;

endpackage

// File: rtl/gpio_bus_guard.sv
module gpio_bus_guard #(
   parameter int SETTLE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_en,
   output logic acc_ok
);
   localparam int CW = $clog2(SETTLE + 1);

   if (SETTLE < 1) begin : g_bad_settle
      $error("gpio_bus_guard: SETTLE must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!clk_en)
         cnt_q <= '0;
      else if (cnt_q != CW'(SETTLE))
         cnt_q <= cnt_q + 1'b1;
   end

   assign acc_ok = clk_en && (cnt_q == CW'(SETTLE));

   // R9: no access is accepted on the edge where the enable first appears
   a_r9_no_early_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> !acc_ok);

endmodule

// File: rtl/gpio_pad_cfg.sv
module gpio_pad_cfg #(
   parameter int W         = 8,
   parameter int RST_DRIVE = 0   // 0 low, 1 medium, 2 high
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_lo,
   input  logic         we_md,
   input  logic         we_hi,
   input  logic         we_od,
   input  logic         we_pu,
   input  logic         we_pd,
   input  logic [W-1:0] wd,
   output logic [W-1:0] drv_lo,
   output logic [W-1:0] drv_md,
   output logic [W-1:0] drv_hi,
   output logic [W-1:0] od,
   output logic [W-1:0] pu,
   output logic [W-1:0] pd
);
   localparam logic [W-1:0] ONES = '1;
   localparam logic [W-1:0] ZERO = '0;

   if (RST_DRIVE < 0 || RST_DRIVE > 2) begin : g_bad_drive
      $error("gpio_pad_cfg: RST_DRIVE must be 0, 1 or 2");
   end

   logic [W-1:0] rst_lo, rst_md, rst_hi;
   if (RST_DRIVE == 2) begin : g_rst_hi
      assign rst_lo = ZERO; assign rst_md = ZERO; assign rst_hi = ONES;
   end else if (RST_DRIVE == 1) begin : g_rst_md
      assign rst_lo = ZERO; assign rst_md = ONES; assign rst_hi = ZERO;
   end else begin : g_rst_lo
      assign rst_lo = ONES; assign rst_md = ZERO; assign rst_hi = ZERO;
   end

   // Drive selects: setting a bit in one clears it in the other two
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_lo <= rst_lo;
         drv_md <= rst_md;
         drv_hi <= rst_hi;
      end else if (we_lo) begin
         drv_lo <= drv_lo | wd;
         drv_md <= drv_md & ~wd;
         drv_hi <= drv_hi & ~wd;
      end else if (we_md) begin
         drv_lo <= drv_lo & ~wd;
         drv_md <= drv_md | wd;
         drv_hi <= drv_hi & ~wd;
      end else if (we_hi) begin
         drv_lo <= drv_lo & ~wd;
         drv_md <= drv_md & ~wd;
         drv_hi <= drv_hi | wd;
      end
   end

   // Pulls: each write loads its own register and knocks out the partner
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pu <= '0;
         pd <= '0;
      end else if (we_pu) begin
         pu <= wd;
         pd <= pd & ~wd;
      end else if (we_pd) begin
         pd <= wd;
         pu <= pu & ~wd;
      end
   end

   // Open-drain stands alone
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         od <= '0;
      else if (we_od)
         od <= wd;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin_chk
      // R4: one drive strength per pin at all times
      a_r4_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
         $countones({drv_lo[i], drv_md[i], drv_hi[i]}) == 1);
   end

   // R5: pulls never both on
   a_r5_pull_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (pu & pd) == '0);

   // R6: open-drain untouched by drive or pull writes
   a_r6_od_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !we_od |=> $stable(od));

endmodule

// File: rtl/gpio_commit_gate.sv
module gpio_commit_gate #(
   parameter int          W         = 8,
   parameter logic [W-1:0] PROT_MASK = 8'h0F,
   parameter logic [31:0] KEY       = 32'hC0DE_7A11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_lock,
   input  logic         we_commit,
   input  logic         we_afsel,
   input  logic         we_den,
   input  logic [31:0]  wd,
   output logic         locked,
   output logic [W-1:0] commit,
   output logic [W-1:0] afsel,
   output logic [W-1:0] den
);
   localparam logic [W-1:0] FREE = ~PROT_MASK;

   logic [W-1:0] wbits;
   assign wbits = wd[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked <= 1'b1;
      else if (we_lock)
         locked <= (wd != KEY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         commit <= FREE;
      else if (we_commit && !locked)
         commit <= wbits | FREE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         afsel <= '0;
         den   <= '0;
      end else begin
         if (we_afsel) afsel <= (afsel & ~commit) | (wbits & commit);
         if (we_den)   den   <= (den   & ~commit) | (wbits & commit);
      end
   end

   // R7: a wrong key always leaves the port locked
   a_r7_bad_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lock && wd != KEY) |=> locked);

   // R8: commit frozen while locked
   a_r8_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(commit));

   // R8: uncommitted protected pins keep their function select
   a_r8_afsel_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      we_afsel |=> ((afsel ^ $past(afsel)) & PROT_MASK & ~$past(commit)) == '0);

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int          W           = 8,
   parameter int          ADDR_W      = 10,
   parameter int          SYNC_STAGES = 2,
   parameter int          SETTLE      = 3,
   parameter int          RST_DRIVE   = 0,
   parameter logic [7:0]  PROT_MASK   = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   input  logic [W-1:0]      pin_in,
   output logic [W-1:0]      pad_out,
   output logic [W-1:0]      pad_oe,
   output logic [W-1:0]      pad_drv_lo,
   output logic [W-1:0]      pad_drv_mid,
   output logic [W-1:0]      pad_drv_hi,
   output logic [W-1:0]      pad_pu,
   output logic [W-1:0]      pad_pd,
   output logic [W-1:0]      pad_od,
   output logic [W-1:0]      pad_afsel,
   output logic [W-1:0]      pad_den
);
   localparam int HI_W = ADDR_W - W;

   if (W < 1 || W > 8) begin : g_bad_width
      $error("gpio_port_regs: W must be 1..8");
   end
   if (ADDR_W != 10) begin : g_bad_addr
      $error("gpio_port_regs: ADDR_W must be 10 to match the register map");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("gpio_port_regs: SYNC_STAGES must not be negative");
   end

   // ---------------- access guard ----------------
   logic acc_ok;
   gpio_bus_guard #(.SETTLE(SETTLE)) i_guard (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .acc_ok(acc_ok)
   );

   // ---------------- decode ----------------
   logic     in_window;
   reg_sel_e sel;
   assign in_window = (bus_addr[ADDR_W-1:W] == HI_W'(0));

   always_comb begin
      sel = SEL_NONE;
      if (in_window) sel = SEL_DATA;
      else begin
         unique case (bus_addr)
            A_DIR:    sel = SEL_DIR;
            A_AFSEL:  sel = SEL_AFSEL;
            A_DRV_LO: sel = SEL_DRV_LO;
            A_DRV_MD: sel = SEL_DRV_MD;
            A_DRV_HI: sel = SEL_DRV_HI;
            A_OD:     sel = SEL_OD;
            A_PU:     sel = SEL_PU;
            A_PD:     sel = SEL_PD;
            A_DEN:    sel = SEL_DEN;
            A_LOCK:   sel = SEL_LOCK;
            A_COMMIT: sel = SEL_COMMIT;
            default:  sel = SEL_NONE;
         endcase
      end
   end

   logic wr_ok, rd_ok;
   assign wr_ok = bus_wr && acc_ok;
   assign rd_ok = bus_rd && acc_ok;

   logic [W-1:0] amask, wbits;
   assign amask = bus_addr[W-1:0];
   assign wbits = bus_wdata[W-1:0];

   // ---------------- data and direction ----------------
   logic [W-1:0] data_q, dir_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else if (wr_ok) begin
         if (sel == SEL_DATA) data_q <= (data_q & ~amask) | (wbits & amask);
         if (sel == SEL_DIR)  dir_q  <= wbits;
      end
   end
   assign pad_out = data_q;
   assign pad_oe  = dir_q;

   // ---------------- pin synchroniser ----------------
   logic [W-1:0] pin_s;
   if (SYNC_STAGES == 0) begin : g_no_sync
      assign pin_s = pin_in;
   end else begin : g_sync
      logic [W-1:0] stg_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stg_q[k] <= '0;
         end else begin
            stg_q[0] <= pin_in;
            for (int k = 1; k < SYNC_STAGES; k++) stg_q[k] <= stg_q[k-1];
         end
      end
      assign pin_s = stg_q[SYNC_STAGES-1];
   end

   // ---------------- pad configuration ----------------
   gpio_pad_cfg #(.W(W), .RST_DRIVE(RST_DRIVE)) i_pad_cfg (
      .clk(clk), .rst_n(rst_n),
      .we_lo(wr_ok && sel == SEL_DRV_LO),
      .we_md(wr_ok && sel == SEL_DRV_MD),
      .we_hi(wr_ok && sel == SEL_DRV_HI),
      .we_od(wr_ok && sel == SEL_OD),
      .we_pu(wr_ok && sel == SEL_PU),
      .we_pd(wr_ok && sel == SEL_PD),
      .wd(wbits),
      .drv_lo(pad_drv_lo), .drv_md(pad_drv_mid), .drv_hi(pad_drv_hi),
      .od(pad_od), .pu(pad_pu), .pd(pad_pd)
   );

   // ---------------- lock and commit ----------------
   logic         locked;
   logic [W-1:0] commit;
   gpio_commit_gate #(.W(W), .PROT_MASK(PROT_MASK[W-1:0]), .KEY(UNLOCK_KEY)) i_commit (
      .clk(clk), .rst_n(rst_n),
      .we_lock(wr_ok && sel == SEL_LOCK),
      .we_commit(wr_ok && sel == SEL_COMMIT),
      .we_afsel(wr_ok && sel == SEL_AFSEL),
      .we_den(wr_ok && sel == SEL_DEN),
      .wd(bus_wdata),
      .locked(locked), .commit(commit), .afsel(pad_afsel), .den(pad_den)
   );

   // ---------------- read response ----------------
   logic [W-1:0] rbits;
   always_comb begin
      rbits = '0;
      unique case (sel)
         SEL_DATA:   rbits = pin_s & amask;
         SEL_DIR:    rbits = dir_q;
         SEL_AFSEL:  rbits = pad_afsel;
         SEL_DRV_LO: rbits = pad_drv_lo;
         SEL_DRV_MD: rbits = pad_drv_mid;
         SEL_DRV_HI: rbits = pad_drv_hi;
         SEL_OD:     rbits = pad_od;
         SEL_PU:     rbits = pad_pu;
         SEL_PD:     rbits = pad_pd;
         SEL_DEN:    rbits = pad_den;
         SEL_LOCK:   rbits = W'(locked);
         SEL_COMMIT: rbits = commit;
         default:    rbits = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= rd_ok ? 32'(rbits) : 32'h0;
         bus_err   <= (bus_rd || bus_wr) && !acc_ok;
      end
   end

   // R2: a masked write leaves unmasked pins alone
   a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && in_window) |=> ((data_q ^ $past(data_q)) & ~$past(amask)) == '0);

   // R9: a refused access changes no output data
   a_r9_err_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> ($stable(data_q) && bus_rdata == 32'h0));

   // R11: no read, no data
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == 32'h0);

endmodule

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [7:0]  pin_in = 8'h3C;
   logic [7:0]  pad_out, pad_oe, pad_drv_lo, pad_drv_mid, pad_drv_hi;
   logic [7:0]  pad_pu, pad_pd, pad_od, pad_afsel, pad_den;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   gpio_port_regs i_gpio_port_regs (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_drv_lo(pad_drv_lo), .pad_drv_mid(pad_drv_mid), .pad_drv_hi(pad_drv_hi),
      .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_od(pad_od),
      .pad_afsel(pad_afsel), .pad_den(pad_den)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   logic last_err;
   logic [31:0] last_rd;

   task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      last_err = bus_err;
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [9:0] a);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      last_err = bus_err;
      last_rd  = bus_rdata;
      bus_rd = 1'b0;
   endtask

   // op: 0 write, 1 read and compare, 2 compare pad_out ; fields {op,addr,data,exp,req}
   localparam int NV = 54;
   localparam logic [79:0] VEC [NV] = '{
      {2'd0, 10'h100, 32'h0000_00FF, 32'h0, 4'd10},   // R10 all outputs
      {2'd1, 10'h100, 32'h0,         32'hFF, 4'd10},
      {2'd0, 10'h0FF, 32'h0000_00A5, 32'h0, 4'd2},    // R2 full mask
      {2'd2, 10'h000, 32'h0,         32'hA5, 4'd2},
      {2'd0, 10'h008, 32'h0000_00FF, 32'h0, 4'd2},    // R2 bit 3 only
      {2'd2, 10'h000, 32'h0,         32'hAD, 4'd2},
      {2'd0, 10'h008, 32'h0000_0000, 32'h0, 4'd2},
      {2'd2, 10'h000, 32'h0,         32'hA5, 4'd2},
      {2'd0, 10'h0F0, 32'h0000_000F, 32'h0, 4'd2},    // R2 upper nibble cleared
      {2'd2, 10'h000, 32'h0,         32'h05, 4'd2},
      {2'd1, 10'h0FF, 32'h0,         32'h3C, 4'd3},   // R3 full mask read
      {2'd1, 10'h00F, 32'h0,         32'h0C, 4'd3},
      {2'd1, 10'h000, 32'h0,         32'h00, 4'd3},
      {2'd0, 10'h142, 32'h0000_0003, 32'h0, 4'd4},    // R4 high drive on 1:0
      {2'd1, 10'h142, 32'h0,         32'h03, 4'd4},
      {2'd1, 10'h140, 32'h0,         32'hFC, 4'd4},
      {2'd1, 10'h141, 32'h0,         32'h00, 4'd4},
      {2'd0, 10'h141, 32'h0000_0006, 32'h0, 4'd4},    // R4 medium on 2:1
      {2'd1, 10'h142, 32'h0,         32'h01, 4'd4},
      {2'd1, 10'h141, 32'h0,         32'h06, 4'd4},
      {2'd1, 10'h140, 32'h0,         32'hF8, 4'd4},
      {2'd0, 10'h140, 32'h0000_0000, 32'h0, 4'd4},    // R4 zero write no effect
      {2'd1, 10'h140, 32'h0,         32'hF8, 4'd4},
      {2'd0, 10'h144, 32'h0000_000F, 32'h0, 4'd5},    // R5 pull-up
      {2'd1, 10'h144, 32'h0,         32'h0F, 4'd5},
      {2'd0, 10'h145, 32'h0000_003C, 32'h0, 4'd5},    // R5 pull-down knocks out
      {2'd1, 10'h144, 32'h0,         32'h03, 4'd5},
      {2'd1, 10'h145, 32'h0,         32'h3C, 4'd5},
      {2'd0, 10'h144, 32'h0000_0000, 32'h0, 4'd5},    // R5 first clearing write
      {2'd1, 10'h144, 32'h0,         32'h00, 4'd5},
      {2'd1, 10'h145, 32'h0,         32'h3C, 4'd5},
      {2'd0, 10'h145, 32'h0000_0000, 32'h0, 4'd5},    // R5 second clearing write
      {2'd1, 10'h145, 32'h0,         32'h00, 4'd5},
      {2'd0, 10'h143, 32'h0000_00FF, 32'h0, 4'd6},    // R6 open-drain alone
      {2'd1, 10'h143, 32'h0,         32'hFF, 4'd6},
      {2'd1, 10'h144, 32'h0,         32'h00, 4'd6},
      {2'd1, 10'h140, 32'h0,         32'hF8, 4'd6},
      {2'd1, 10'h148, 32'h0,         32'h01, 4'd7},   // R7 locked at start
      {2'd0, 10'h148, 32'h1234_5678, 32'h0, 4'd7},
      {2'd1, 10'h148, 32'h0,         32'h01, 4'd7},
      {2'd0, 10'h149, 32'h0000_00FF, 32'h0, 4'd8},    // R8 commit ignored locked
      {2'd1, 10'h149, 32'h0,         32'hF0, 4'd8},
      {2'd0, 10'h148, 32'hC0DE_7A11, 32'h0, 4'd7},    // R7 unlock
      {2'd1, 10'h148, 32'h0,         32'h00, 4'd7},
      {2'd0, 10'h108, 32'h0000_00FF, 32'h0, 4'd8},    // R8 protected blocked
      {2'd1, 10'h108, 32'h0,         32'hF0, 4'd8},
      {2'd0, 10'h147, 32'h0000_00FF, 32'h0, 4'd8},
      {2'd1, 10'h147, 32'h0,         32'hF0, 4'd8},
      {2'd0, 10'h149, 32'h0000_0003, 32'h0, 4'd8},    // R8 commit pins 1:0
      {2'd1, 10'h149, 32'h0,         32'hF3, 4'd8},
      {2'd0, 10'h108, 32'h0000_00FF, 32'h0, 4'd8},
      {2'd1, 10'h108, 32'h0,         32'hF3, 4'd8},
      {2'd0, 10'h148, 32'h0000_0000, 32'h0, 4'd7},    // R7 relock
      {2'd1, 10'h1FF, 32'h0,         32'h00, 4'd11}   // R11 unmapped reads zero
   };

   initial begin
      #(200000 * 20);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pad_oe", 32'(pad_oe), 32'h0);
      check("R1 pad_out", 32'(pad_out), 32'h0);
      check("R1 drive", {8'h0, pad_drv_hi, pad_drv_mid, pad_drv_lo}, 32'h0000_00FF);
      check("R1 pulls od", {8'h0, pad_pu, pad_pd, pad_od}, 32'h0);
      check("R1 afsel den", {16'h0, pad_afsel, pad_den}, 32'h0);

      // R9 clock enable low: refused
      bus_read(10'h148);
      check("R9 err clk_en low", 32'(last_err), 32'h1);
      check("R9 rdata zero", last_rd, 32'h0);

      // R9 settling window: three refused, fourth accepted
      clk_en = 1'b1;
      bus_write(10'h0FF, 32'h0000_00FF);
      check("R9 err edge1", 32'(last_err), 32'h1);
      check("R9 write ignored", 32'(pad_out), 32'h0);
      bus_read(10'h148);
      check("R9 err edge2", 32'(last_err), 32'h1);
      bus_read(10'h148);
      check("R9 err edge3", 32'(last_err), 32'h1);
      bus_read(10'h148);
      check("R9 ok edge4", 32'(last_err), 32'h0);
      check("R1 lock reads one", last_rd, 32'h1);
      @(negedge clk);
      check("R11 idle rdata", bus_rdata, 32'h0);

      for (int v = 0; v < NV; v++) begin
         logic [1:0]  op;
         logic [9:0]  a;
         logic [31:0] d, e;
         logic [3:0]  rq;
         string       tag;
         {op, a, d, e, rq} = VEC[v];
         tag = $sformatf("R%0d vec%0d", rq, v);
         if (op == 2'd0) begin
            bus_write(a, d);
            check({tag, " err"}, 32'(last_err), 32'h0);
         end else if (op == 2'd1) begin
            bus_read(a);
            check(tag, last_rd, e);
         end else begin
            check(tag, 32'(pad_out), e);
         end
      end

      // R10 pads follow registers; R4 R6 R8 pad views
      check("R10 pad_oe", 32'(pad_oe), 32'hFF);
      check("R10 pad_out", 32'(pad_out), 32'h05);
      check("R4 pad drive", {8'h0, pad_drv_hi, pad_drv_mid, pad_drv_lo}, 32'h0001_06F8);
      check("R6 pad od", 32'(pad_od), 32'hFF);
      check("R8 pad afsel", 32'(pad_afsel), 32'hF3);
      check("R8 pad den", 32'(pad_den), 32'hF0);

      // R8 commit ignored after relock
      bus_write(10'h149, 32'h0000_00FF);
      bus_read(10'h149);
      check("R8 commit after relock", last_rd, 32'hF3);

      // R3 pin change seen through the synchroniser
      pin_in = 8'hC3;
      repeat (3) @(negedge clk);
      bus_read(10'h0FF);
      check("R3 new pins", last_rd, 32'hC3);

      // R9 enable drop restarts the window
      clk_en = 1'b0;
      @(negedge clk);
      clk_en = 1'b1;
      bus_write(10'h0FF, 32'h0);
      check("R9 restart err", 32'(last_err), 32'h1);
      check("R9 restart no write", 32'(pad_out), 32'h05);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule